// File: doc/BRIEF.md
# Shared SPI Bus Arbiter With Exclusive Lock

This block lets up to three device requesters share one SPI transaction engine. Each device has its own chip-select line. A requester holds its request line high together with a transaction descriptor. The arbiter picks one requester, passes that descriptor to the engine with a one-cycle start pulse, and drives low only that device's chip select. When the engine reports completion, the arbiter pulses a completion strobe back to the requester. The requester then drops its request.

A transaction is atomic: once granted, it cannot be displaced. A requester may also take an exclusive lock on the bus so that it can issue several transactions back to back. While the lock is held, all other devices wait. A request can be flagged as polling-class. The bus then stays reserved after the engine finishes, until the requester signals an explicit end. Requests that are neither locked out nor waiting for a held bus are served in rotating order.

Top module: `spi_bus_arbiter`

## Requirements
- R1: After reset all chip selects are high, no grant is driven, the lock is free, and neither the start nor any completion strobe is active.
- R2: When the bus is free and a device request is seen on a clock edge, the next cycle shows the grant bit of that device (bit i for device i) and drives only that device's chip select low. In that same cycle the arbiter gives one start pulse carrying that device's descriptor slice (bits i*DW to i*DW+DW-1).
- R3: A granted transaction is atomic. Its grant does not change until the engine reports done, whatever other requests arrive. The cycle after done is sampled, that device's completion bit pulses for one cycle and all chip selects return high.
- R4: When several requests compete, the first requesting index after the last granted index wins, counting upward and wrapping. After reset the last granted index is NDEV-1, so device 0 has first priority.
- R5: An acquire request is taken only when no transaction is in flight. The lock appears one cycle later on the lock-valid and lock-owner outputs. An acquire raised during a transaction waits for that transaction to finish.
- R6: While the lock is held, only the owner's requests are granted. Other devices' requests stay pending.
- R7: A release from the owner during a transaction takes effect after that transaction finishes: lock-valid falls two cycles after the completion strobe. A release while idle frees the lock within two cycles.
- R8: A release pulse from a device that does not own the lock has no effect on the lock or on grants.
- R9: After a polling-class transaction completes, the grant remains on that device with all chip selects high. No other transaction starts until that device pulses its own end input. End pulses from other devices are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | NDEV | Per-device transaction request, held until its completion strobe |
| poll_i | input | NDEV | Per-device polling-class flag, sampled with the grant |
| desc_i | input | NDEV*DW | Per-device descriptors, device i in slice i |
| acq_i | input | NDEV | Per-device lock acquire request, held until ownership shows |
| rel_i | input | NDEV | Per-device lock release pulse |
| poll_end_i | input | NDEV | Per-device end handshake for polling-class transactions |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_start_o | output | 1 | One-cycle start to the engine |
| eng_desc_o | output | DW | Descriptor routed to the engine |
| cs_n_o | output | NDEV | Active-low chip selects |
| gnt_o | output | NDEV | One-hot grant, held through the transaction and any polling hold |
| done_o | output | NDEV | One-cycle completion strobe per device |
| lock_vld_o | output | 1 | Lock held |
| lock_own_o | output | 2 | Index of lock owner |

## Verification
A grant, chip select and start pulse are due one cycle after the edge that samples the request. A completion strobe is due one cycle after the edge that samples engine done. A lock appears one cycle after an idle edge sees acquire, and an in-flight release frees it two cycles after the completion strobe. Inputs are driven on falling edges and outputs are sampled on falling edges. A monitor compares each start pulse, at the falling edge right after it rises, against the next entry in a queue of expected device and descriptor pairs. The same monitor checks the completion strobe at the falling edge after it drove engine done. Blocking behaviour is checked by holding off several cycles and confirming that neither a start nor a grant change appears.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] last_idx,
  output logic          pick_vld,
  output logic [IW-1:0] pick_idx
);
  int j;
  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    j = 0;
    for (int k = 1; k <= N; k++) begin
      j = (int'(last_idx) + k) % N;
      if (!pick_vld && cand[j]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end
endmodule

// File: rtl/arb_lock_ctrl.sv
module arb_lock_ctrl #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          boundary,
  input  logic [N-1:0]  rel,
  input  logic          acq_vld,
  input  logic [IW-1:0] acq_idx,
  output logic          lock_vld,
  output logic [IW-1:0] lock_own,
  output logic          lock_act
);
  logic          vld_q, vld_d;
  logic [IW-1:0] own_q, own_d;
  logic          rp_q, rp_d;
  logic          en;

  always_comb begin
    vld_d    = vld_q;
    own_d    = own_q;
    rp_d     = rp_q;
    lock_act = 1'b0;
    if (boundary && rp_q) begin
      vld_d    = 1'b0;
      rp_d     = 1'b0;
      lock_act = 1'b1;
    end else begin
      if (boundary && !vld_q && acq_vld) begin
        vld_d    = 1'b1;
        own_d    = acq_idx;
        lock_act = 1'b1;
      end
      if (vld_q && rel[own_q]) rp_d = 1'b1;
    end
    en = (vld_d != vld_q) || (own_d != own_q) || (rp_d != rp_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      own_q <= '0;
      rp_q  <= 1'b0;
    end else if (en) begin
      vld_q <= vld_d;
      own_q <= own_d;
      rp_q  <= rp_d;
    end
  end

  assign lock_vld = vld_q;
  assign lock_own = own_q;

  p_acq_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(vld_q) |-> $past(boundary));
  p_foreign_rel_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (vld_q && !rp_q && !rel[own_q]) |=> !rp_q);
endmodule

// File: rtl/arb_xfer_fsm.sv
module arb_xfer_fsm
  import spi_arb_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          pick_vld,
  input  logic [IW-1:0] pick_idx,
  input  logic          lock_act,
  input  logic [N-1:0]  poll,
  input  logic [N*DW-1:0] desc,
  input  logic          eng_done,
  input  logic [N-1:0]  poll_end,
  output logic          boundary,
  output logic [IW-1:0] last_idx,
  output logic [N-1:0]  gnt,
  output logic [N-1:0]  cs_n,
  output logic          eng_start,
  output logic [DW-1:0] eng_desc,
  output logic [N-1:0]  dev_done
);
  arb_state_e    st_q, st_d;
  logic [IW-1:0] own_q, own_d, last_q, last_d;
  logic          pol_q, pol_d, start_q, start_d;
  logic [N-1:0]  gnt_q, gnt_d, cs_q, cs_d, done_q, done_d;
  logic [DW-1:0] desc_q, desc_d;
  logic          desc_en;

  always_comb begin
    st_d    = st_q;
    own_d   = own_q;
    last_d  = last_q;
    pol_d   = pol_q;
    gnt_d   = gnt_q;
    cs_d    = cs_q;
    desc_d  = desc_q;
    start_d = 1'b0;
    done_d  = '0;
    desc_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pick_vld && !lock_act) begin
        st_d    = ST_RUN;
        own_d   = pick_idx;
        last_d  = pick_idx;
        pol_d   = poll[pick_idx];
        gnt_d   = N'(1) << pick_idx;
        cs_d    = ~(N'(1) << pick_idx);
        desc_d  = desc[pick_idx*DW +: DW];
        desc_en = 1'b1;
        start_d = 1'b1;
      end
      ST_RUN: if (eng_done) begin
        st_d   = ST_DONE;
        cs_d   = '1;
        done_d = gnt_q;
      end
      ST_DONE: begin
        if (pol_q) st_d = ST_HOLD;
        else begin
          st_d  = ST_IDLE;
          gnt_d = '0;
        end
      end
      ST_HOLD: if (poll_end[own_q]) begin
        st_d  = ST_IDLE;
        gnt_d = '0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      own_q   <= '0;
      last_q  <= IW'(N-1);
      pol_q   <= 1'b0;
      gnt_q   <= '0;
      cs_q    <= '1;
      start_q <= 1'b0;
      done_q  <= '0;
      desc_q  <= '0;
    end else begin
      st_q    <= st_d;
      own_q   <= own_d;
      last_q  <= last_d;
      pol_q   <= pol_d;
      gnt_q   <= gnt_d;
      cs_q    <= cs_d;
      start_q <= start_d;
      done_q  <= done_d;
      if (desc_en) desc_q <= desc_d;
    end
  end

  assign boundary  = (st_q == ST_IDLE);
  assign last_idx  = last_q;
  assign gnt       = gnt_q;
  assign cs_n      = cs_q;
  assign eng_start = start_q;
  assign eng_desc  = desc_q;
  assign dev_done  = done_q;

  p_atomic_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_RUN && !eng_done) |=> (st_q == ST_RUN && $stable(gnt_q)));
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |=> !start_q);
  p_poll_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_HOLD && !poll_end[own_q]) |=> (st_q == ST_HOLD && $stable(gnt_q)));
endmodule

// File: rtl/spi_bus_arbiter.sv
module spi_bus_arbiter #(
  parameter int NDEV = 3,
  parameter int DW   = 16,
  localparam int IW  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDEV-1:0]   req_i,
  input  logic [NDEV-1:0]   poll_i,
  input  logic [NDEV*DW-1:0] desc_i,
  input  logic [NDEV-1:0]   acq_i,
  input  logic [NDEV-1:0]   rel_i,
  input  logic [NDEV-1:0]   poll_end_i,
  input  logic              eng_done_i,
  output logic              eng_start_o,
  output logic [DW-1:0]     eng_desc_o,
  output logic [NDEV-1:0]   cs_n_o,
  output logic [NDEV-1:0]   gnt_o,
  output logic [NDEV-1:0]   done_o,
  output logic              lock_vld_o,
  output logic [IW-1:0]     lock_own_o
);
  logic [1:0]      rs_q;
  logic            rst_ni;
  logic            boundary, lock_act, lock_vld;
  logic [IW-1:0]   lock_own, last_idx;
  logic [NDEV-1:0] own_mask, cand;
  logic            pick_vld, acq_vld;
  logic [IW-1:0]   pick_idx, acq_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign own_mask = NDEV'(1) << lock_own;
  assign cand     = lock_vld ? (req_i & own_mask) : req_i;

  arb_rr_pick #(.N(NDEV)) u_xfer_pick (
    .cand(cand), .last_idx(last_idx), .pick_vld(pick_vld), .pick_idx(pick_idx));

  arb_rr_pick #(.N(NDEV)) u_acq_pick (
    .cand(acq_i), .last_idx(last_idx), .pick_vld(acq_vld), .pick_idx(acq_idx));

  arb_lock_ctrl #(.N(NDEV)) u_lock (
    .clk(clk), .rst_ni(rst_ni), .boundary(boundary), .rel(rel_i),
    .acq_vld(acq_vld), .acq_idx(acq_idx),
    .lock_vld(lock_vld), .lock_own(lock_own), .lock_act(lock_act));

  arb_xfer_fsm #(.N(NDEV), .DW(DW)) u_fsm (
    .clk(clk), .rst_ni(rst_ni), .pick_vld(pick_vld), .pick_idx(pick_idx),
    .lock_act(lock_act), .poll(poll_i), .desc(desc_i), .eng_done(eng_done_i),
    .poll_end(poll_end_i), .boundary(boundary), .last_idx(last_idx),
    .gnt(gnt_o), .cs_n(cs_n_o), .eng_start(eng_start_o), .eng_desc(eng_desc_o),
    .dev_done(done_o));

  assign lock_vld_o = lock_vld;
  assign lock_own_o = lock_own;

  p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  p_lock_excl_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_vld && gnt_o != '0) |-> (gnt_o == own_mask));
  p_free_at_idle_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(lock_vld) |-> (gnt_o == '0));
endmodule

// File: tb/tb_spi_bus_arbiter.sv
module tb_spi_bus_arbiter;
  localparam int NDEV = 3;
  localparam int DW   = 16;
  localparam int LAT  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NDEV-1:0]    req = '0, poll = '0, acq = '0, rel = '0, pend = '0;
  logic [NDEV*DW-1:0] desc = '0;
  logic               eng_done = 1'b0;
  logic               eng_start;
  logic [DW-1:0]      eng_desc;
  logic [NDEV-1:0]    cs_n, gnt, done;
  logic               lock_vld;
  logic [1:0]         lock_own;

  int total = 0, bad = 0, cyc = 0, eng_cnt = -1, cur_dev = 0;
  int exp_dev[$];
  logic [DW-1:0] exp_desc[$];

  always #10 clk = ~clk;

  spi_bus_arbiter #(.NDEV(NDEV), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .poll_i(poll), .desc_i(desc),
    .acq_i(acq), .rel_i(rel), .poll_end_i(pend), .eng_done_i(eng_done),
    .eng_start_o(eng_start), .eng_desc_o(eng_desc), .cs_n_o(cs_n), .gnt_o(gnt),
    .done_o(done), .lock_vld_o(lock_vld), .lock_own_o(lock_own));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_xfer(input int d, input logic [DW-1:0] v);
    exp_dev.push_back(d);
    exp_desc.push_back(v);
  endtask

  task automatic raise(input int d, input logic [DW-1:0] v, input bit p);
    desc[d*DW +: DW] = v;
    poll[d] = p;
    req[d] = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (exp_dev.size() == 0 && gnt == '0 && req == '0 && eng_cnt < 0 && !eng_done) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(input int d);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done[d]) break;
    end
  endtask

  // monitor, engine model and requester drop
  always @(negedge clk) begin
    if (eng_done) begin
      chk(done == (NDEV'(1) << cur_dev), "R3 done strobe", done, NDEV'(1) << cur_dev);
      chk(cs_n == '1, "R3 cs released", cs_n, '1);
      req[cur_dev] = 1'b0;
      eng_done = 1'b0;
    end
    if (eng_start) begin
      if (exp_dev.size() == 0) begin
        chk(1'b0, "R6/R9 unexpected start", gnt, 0);
      end else begin
        cur_dev = exp_dev.pop_front();
        chk(gnt == (NDEV'(1) << cur_dev), "R2/R4 grant", gnt, NDEV'(1) << cur_dev);
        chk(cs_n == ~(NDEV'(1) << cur_dev), "R2 chip select", cs_n, ~(NDEV'(1) << cur_dev));
        chk(eng_desc == exp_desc.pop_front(), "R2 descriptor", eng_desc, 0);
      end
      eng_cnt = LAT;
    end else if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) begin
        eng_done = 1'b1;
        eng_cnt = -1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_n == '1, "R1 cs idle", cs_n, '1);
    chk(gnt == '0 && done == '0, "R1 no grant", gnt, 0);
    chk(!lock_vld && !eng_start, "R1 lock free", lock_vld, 0);

    // R2, R3, R4: single request, then two arrive during it
    expect_xfer(1, 16'h1111);
    raise(1, 16'h1111, 1'b0);
    @(negedge clk);
    chk(gnt == 3'b010, "R2 grant next cycle", gnt, 3'b010);
    raise(0, 16'h0A0A, 1'b0);
    raise(2, 16'h2B2B, 1'b0);
    expect_xfer(2, 16'h2B2B);
    expect_xfer(0, 16'h0A0A);
    repeat (2) @(negedge clk);
    chk(gnt == 3'b010, "R3 atomic grant", gnt, 3'b010);
    wait_idle();

    // R4: all three at once, last granted was 0
    expect_xfer(1, 16'h1001);
    expect_xfer(2, 16'h2002);
    expect_xfer(0, 16'h0003);
    raise(0, 16'h0003, 1'b0);
    raise(1, 16'h1001, 1'b0);
    raise(2, 16'h2002, 1'b0);
    wait_idle();

    // R5, R6: device 2 takes the lock
    acq[2] = 1'b1;
    @(negedge clk);
    chk(lock_vld && lock_own == 2'd2, "R5 lock taken", {lock_vld, lock_own}, 3'b110);
    acq[2] = 1'b0;
    expect_xfer(2, 16'h2C2C);
    raise(0, 16'h0C0C, 1'b0);
    raise(2, 16'h2C2C, 1'b0);
    wait_done(2);
    repeat (4) @(negedge clk);
    chk(gnt == '0 && req[0], "R6 others held off", gnt, 0);
    // R8: foreign release
    rel[0] = 1'b1;
    @(negedge clk);
    rel[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk(lock_vld && lock_own == 2'd2, "R8 foreign release ignored", {lock_vld, lock_own}, 3'b110);
    chk(gnt == '0, "R8 no grant after foreign release", gnt, 0);
    // R7: release during the owner's transaction
    expect_xfer(2, 16'h2D2D);
    expect_xfer(0, 16'h0C0C);
    raise(2, 16'h2D2D, 1'b0);
    @(negedge clk);
    rel[2] = 1'b1;
    @(negedge clk);
    rel[2] = 1'b0;
    chk(lock_vld, "R7 lock kept in flight", lock_vld, 1);
    wait_done(2);
    chk(lock_vld, "R7 lock kept at done", lock_vld, 1);
    @(negedge clk);
    chk(lock_vld, "R7 lock kept one cycle after done", lock_vld, 1);
    @(negedge clk);
    chk(!lock_vld, "R7 lock freed two cycles after done", lock_vld, 0);
    wait_idle();

    // R5: acquire raised while busy waits for the boundary
    expect_xfer(1, 16'h1E1E);
    raise(1, 16'h1E1E, 1'b0);
    @(negedge clk);
    acq[0] = 1'b1;
    @(negedge clk);
    chk(!lock_vld, "R5 acquire waits in flight", lock_vld, 0);
    wait_done(1);
    chk(!lock_vld, "R5 acquire waits until done", lock_vld, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (lock_vld) break;
    end
    chk(lock_vld && lock_own == 2'd0, "R5 acquire at boundary", {lock_vld, lock_own}, 3'b100);
    acq[0] = 1'b0;
    rel[0] = 1'b1;
    @(negedge clk);
    rel[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(!lock_vld, "R7 idle release", lock_vld, 0);
    wait_idle();

    // R9: polling-class transaction holds the bus until its end
    expect_xfer(0, 16'h0F0F);
    raise(0, 16'h0F0F, 1'b1);
    wait_done(0);
    raise(1, 16'h1F1F, 1'b0);
    repeat (5) @(negedge clk);
    chk(gnt == 3'b001 && cs_n == '1, "R9 bus held after done", {gnt, cs_n}, 6'b001111);
    pend[1] = 1'b1;
    @(negedge clk);
    pend[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk(gnt == 3'b001, "R9 foreign end ignored", gnt, 3'b001);
    expect_xfer(1, 16'h1F1F);
    pend[0] = 1'b1;
    @(negedge clk);
    pend[0] = 1'b0;
    wait_idle();
    chk(exp_dev.size() == 0, "R9 queue drained", exp_dev.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule